// File: doc/BRIEF.md
# Multiplexed Wide-Bus Peripheral Demultiplexer

This block sits on the peripheral side of a 32-line shared expansion bus, where the same lines first carry an address and then carry data. A cycle on the wide bus is marked by an active-low wide-cycle strobe. The legacy byte-wide data strobe stays idle during these cycles, so older 8-bit cards never see them. A second signal, the phase line, is high while the address is on the lines. When it falls with the strobe held low, the block captures the header from the lines. The header holds the byte selects, a size flag that picks a 32-bit or 16-bit transfer, a reserved burst bit and the address.

The address is compared against a base window given on an input port. A cycle that hits the window with the burst bit low is served from a small bank of 32-bit words inside the block. Writes are taken from the data lanes that the byte selects enable. Reads drive only those lanes back onto the lines through per-line output enables. An active-low acknowledge follows a fixed, parameterised number of clocks after the data phase starts. The block releases the acknowledge and all its lanes when the strobe returns high. All bus inputs are taken as synchronous to the block clock.

Top module: `mxb_demux`

## Requirements
- R1: While reset is held and on the first clock after it, the acknowledge output is high and no output enable is set.
- R2: A 32-bit write that hits the window updates only the bytes of the addressed word whose byte select is high. Header line 31 is byte select 3 (data bits 31..24), line 30 is byte select 2 (23..16), line 1 is byte select 1 (15..8) and line 0 is byte select 0 (7..0). Line 29 is the size flag, 1 for 32-bit. Lines 27..2 are address bits 27..2.
- R3: A 32-bit read that hits the window enables exactly the 8-line groups of the asserted byte selects, and drives the stored bytes on them.
- R4: With the size flag low, the 16-bit value travels on lines 31..16. Byte select 3 covers lines 31..24 as the upper byte and byte select 2 covers lines 23..16 as the lower byte. Header line 1 is address bit 1: 0 picks word bits 31..16 and 1 picks word bits 15..0. Lines 15..0 are never driven.
- R5: The acknowledge goes low exactly ACK_DLY clocks after the clock edge that captures the header, which is the first edge that samples the phase line low after high with the strobe low.
- R6: After the strobe returns high, every output enable is clear at once and the acknowledge is high by the next clock.
- R7: A cycle whose address bits 27..6 differ from the base input drives no lane, gives no acknowledge and changes no stored word.
- R8: A cycle whose header line 28 (reserved burst bit) is high is ignored in the same way as a window miss.
- R9: The header stays held through the data phase, so data on the lines does not change the word, lanes or size being served.
- R10: Toggling the phase line while the strobe is high starts no cycle and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_i | input | 22 | Window base, compared with address bits 27..6 |
| wide_n_i | input | 1 | Active-low wide-cycle strobe |
| mux_ph_i | input | 1 | Phase line, high during the address phase |
| rnw_i | input | 1 | Direction, 1 = read, sampled with the header |
| bus_i | input | 32 | Shared lines as seen by the block |
| bus_o | output | 32 | Read data for the shared lines |
| bus_oe_o | output | 32 | Per-line output enable |
| ack_n_o | output | 1 | Active-low completion acknowledge |

## Verification
Directed cycles write and read one word with every byte select pattern. These show that the byte-select lanes match the stored bytes, and tell a wrong lane from a swapped byte. The 16-bit cycles with address bit 1 at each value are separated from 32-bit ones by a final 32-bit read, which shows which half each one touched. Window misses, a set burst bit and phase toggles with the strobe high are each followed by a hitting read. That read shows the word was left alone. A seeded random mix of sizes, selects, directions and near-window addresses then runs against a bench copy of the word bank. Junk sits on the lines during every data phase, so a header that is not held shows up as wrong data.

// File: rtl/mxb_pkg.sv
// Shared types for the multiplexed wide-bus demultiplexer.
// Assumes a 32-line bus whose header layout is fixed by the protocol.
package mxb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_SKIP = 2'd2
    } mxb_state_e;

    // Header as decoded from the lines during the address phase
    typedef struct packed {
        logic [3:0]  bsel;    // byte selects 3..0 (1..0 forced low in 16-bit)
        logic        size32;  // 1 = 32-bit transfer, 0 = 16-bit
        logic        burst;   // reserved bit, must be low
        logic        rnw;     // 1 = read
        logic [27:1] addr;    // bit 1 meaningful only in 16-bit mode
    } mxb_hdr_t;

endpackage

// File: rtl/mxb_hdr_capture.sv
// Header decode and capture.
// Parses the address-phase lines into a header and holds it from the
// capture edge until a new capture. Assumes cap_en is a single-cycle pulse.
module mxb_hdr_capture
    import mxb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  logic        rnw_i,
    input  logic [31:0] bus_i,
    output mxb_hdr_t    hdr_d,
    output mxb_hdr_t    hdr_q
);

    // Decode the current lines as a header
    always_comb begin
        hdr_d.size32     = bus_i[29];
        hdr_d.burst      = bus_i[28];
        hdr_d.rnw        = rnw_i;
        hdr_d.addr[27:2] = bus_i[27:2];
        if (bus_i[29]) begin
            hdr_d.bsel    = {bus_i[31], bus_i[30], bus_i[1], bus_i[0]};
            hdr_d.addr[1] = 1'b0;
        end else begin
            hdr_d.bsel    = {bus_i[31], bus_i[30], 2'b00};
            hdr_d.addr[1] = bus_i[1];
        end
    end

    // Hold the header captured at the phase edge
    always_ff @(posedge clk) begin
        if (!rst_n)      hdr_q <= '0;
        else if (cap_en) hdr_q <= hdr_d;
    end

endmodule

// File: rtl/mxb_lane_map.sv
// Maps the held header onto byte lanes.
// Gives the storage byte write mask, the bus lane groups to drive, the word
// to write and the read value placed on the lines. In 16-bit mode the value
// travels on lines 31..16 and address bit 1 picks the word half.
module mxb_lane_map
    import mxb_pkg::*;
(
    input  mxb_hdr_t    hdr,
    input  logic [31:0] bus_i,
    input  logic [31:0] word_i,
    output logic [3:0]  wmask_o,
    output logic [3:0]  lane_o,
    output logic [31:0] wword_o,
    output logic [31:0] rbus_o
);

    // Select lanes, mask and data alignment for the transfer size
    always_comb begin
        if (hdr.size32) begin
            lane_o  = hdr.bsel;
            wmask_o = hdr.bsel;
            wword_o = bus_i;
            rbus_o  = word_i;
        end else begin
            lane_o  = {hdr.bsel[3:2], 2'b00};
            wmask_o = hdr.addr[1] ? {2'b00, hdr.bsel[3:2]} : {hdr.bsel[3:2], 2'b00};
            wword_o = {bus_i[31:16], bus_i[31:16]};
            rbus_o  = hdr.addr[1] ? {word_i[15:0], 16'h0000} : {word_i[31:16], 16'h0000};
        end
    end

endmodule

// File: rtl/mxb_word_bank.sv
// Byte-writable bank of 32-bit words served by the demultiplexer.
// Asynchronous read, synchronous masked write, cleared by reset.
module mxb_word_bank #(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    wmask,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);

    logic [31:0] mem [DEPTH];

    // Clear on reset, else write the enabled bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            for (int b = 0; b < 4; b++)
                if (wmask[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/mxb_demux.sv
// Peripheral-side demultiplexer for a 32-line multiplexed expansion bus.
// Captures the header when the phase line falls with the strobe low,
// decodes the window from base_i, serves the word bank and acknowledges
// ACK_DLY clocks after capture. Assumes bus inputs are synchronous to clk.
module mxb_demux
    import mxb_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ACK_DLY = 3,
    localparam int IW      = $clog2(DEPTH),
    localparam int WIN_LSB = 2 + IW,
    localparam int BASE_W  = 28 - WIN_LSB,
    localparam int CW      = $clog2(ACK_DLY + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_i,
    input  logic              wide_n_i,
    input  logic              mux_ph_i,
    input  logic              rnw_i,
    input  logic [31:0]       bus_i,
    output logic [31:0]       bus_o,
    output logic [31:0]       bus_oe_o,
    output logic              ack_n_o
);

    mxb_state_e      state;
    mxb_hdr_t        hdr_d, hdr_q;
    logic            mux_q;
    logic            start, hit, ack_r, ack_set, drive, bank_we;
    logic [CW-1:0]   cnt;
    logic [3:0]      wmask, lane;
    logic [31:0]     wword, word, rbus;

    // Remember the previous phase level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) mux_q <= 1'b1;
        else        mux_q <= mux_ph_i;
    end

    assign start = mux_q && !mux_ph_i && !wide_n_i && (state == ST_IDLE);
    assign hit   = (hdr_d.addr[27:WIN_LSB] == base_i) && !hdr_d.burst;

    mxb_hdr_capture u_hdr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (start),
        .rnw_i  (rnw_i),
        .bus_i  (bus_i),
        .hdr_d  (hdr_d),
        .hdr_q  (hdr_q)
    );

    // Cycle state: serve a hit, sit out a miss, return on strobe release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= hit ? ST_DATA : ST_SKIP;
                ST_DATA: if (wide_n_i) state <= ST_IDLE;
                ST_SKIP: if (wide_n_i) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count clocks of the data phase up to the acknowledge point
    always_ff @(posedge clk) begin
        if (!rst_n)                                              cnt <= '0;
        else if (start)                                          cnt <= '0;
        else if (state == ST_DATA && !wide_n_i && cnt != CW'(ACK_DLY)) cnt <= cnt + 1'b1;
    end

    assign ack_set = (state == ST_DATA) && !wide_n_i && !ack_r && (cnt == CW'(ACK_DLY - 1));

    // Hold the acknowledge until the strobe is released
    always_ff @(posedge clk) begin
        if (!rst_n)                               ack_r <= 1'b0;
        else if (state == ST_DATA && !wide_n_i)   ack_r <= ack_r | ack_set;
        else                                      ack_r <= 1'b0;
    end

    assign ack_n_o = !ack_r;
    assign bank_we = ack_set && !hdr_q.rnw;

    mxb_lane_map u_map (
        .hdr     (hdr_q),
        .bus_i   (bus_i),
        .word_i  (word),
        .wmask_o (wmask),
        .lane_o  (lane),
        .wword_o (wword),
        .rbus_o  (rbus)
    );

    mxb_word_bank #(.DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .wmask (wmask),
        .idx   (hdr_q.addr[WIN_LSB-1:2]),
        .wdata (wword),
        .rdata (word)
    );

    assign drive = (state == ST_DATA) && !wide_n_i && hdr_q.rnw;
    assign bus_o = rbus;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_lane
            assign bus_oe_o[8*g +: 8] = {8{drive && lane[g]}};
        end
    endgenerate

endmodule

// File: rtl/mxb_demux_chk.sv
// Protocol checker for mxb_demux, attached by bind below.
// Observes ports plus the held size flag and the cycle state.
module mxb_demux_chk
    import mxb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_n_i,
    input  logic        ack_n_o,
    input  logic [31:0] bus_oe_o,
    input  logic        size32_q,
    input  mxb_state_e  state_q
);

    // R1: quiet outputs after a reset clock
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (ack_n_o && bus_oe_o == 32'h0));

    // R3: lanes are enabled in whole byte groups
    a_r3_byte_groups: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_oe_o[7:0]   == 8'h00 || bus_oe_o[7:0]   == 8'hFF) &&
         (bus_oe_o[15:8]  == 8'h00 || bus_oe_o[15:8]  == 8'hFF) &&
         (bus_oe_o[23:16] == 8'h00 || bus_oe_o[23:16] == 8'hFF) &&
         (bus_oe_o[31:24] == 8'h00 || bus_oe_o[31:24] == 8'hFF)));

    // R4: a 16-bit cycle never drives lines 15..0
    a_r4_low_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !size32_q |-> (bus_oe_o[15:0] == 16'h0));

    // R5: the acknowledge only begins inside a strobed cycle
    a_r5_ack_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> !$past(wide_n_i));

    // R6: released strobe means no lanes, and acknowledge gone next clock
    a_r6_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        wide_n_i |-> (bus_oe_o == 32'h0));
    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        wide_n_i |=> ack_n_o);

    // R7: an ignored cycle stays silent
    a_r7_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> (ack_n_o && bus_oe_o == 32'h0));

endmodule

bind mxb_demux mxb_demux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wide_n_i (wide_n_i),
    .ack_n_o  (ack_n_o),
    .bus_oe_o (bus_oe_o),
    .size32_q (hdr_q.size32),
    .state_q  (state)
);

// File: tb/tb_mxb_demux.sv
// Self-checking bench for mxb_demux: directed corners plus seeded random cycles.
module tb_mxb_demux;

    localparam int CLK_PERIOD = 10;
    localparam int ACK_DLY    = 3;
    localparam int DEPTH      = 16;
    localparam logic [21:0] BASE = 22'h2A5C1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] base_i = BASE;
    logic        wide_n = 1'b1;
    logic        mux = 1'b1;
    logic        rnw = 1'b1;
    logic [31:0] bus_i = '0;
    logic [31:0] bus_o, bus_oe;
    logic        ack_n;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    mxb_demux #(.DEPTH(DEPTH), .ACK_DLY(ACK_DLY)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_i   (base_i),
        .wide_n_i (wide_n),
        .mux_ph_i (mux),
        .rnw_i    (rnw),
        .bus_i    (bus_i),
        .bus_o    (bus_o),
        .bus_oe_o (bus_oe),
        .ack_n_o  (ack_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_word(input bit sz, input logic [3:0] bs,
                                              input bit burst, input logic [27:0] a);
        return {bs[3], bs[2], sz, burst, a[27:2], sz ? bs[1:0] : {a[1], 1'b0}};
    endfunction

    function automatic logic [3:0] exp_lanes(input bit sz, input logic [3:0] bs);
        return sz ? bs : {bs[3:2], 2'b00};
    endfunction

    function automatic logic [31:0] expand(input logic [3:0] l);
        return {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] w, input bit sz, input bit a1);
        if (sz) return w;
        return a1 ? {w[15:0], 16'h0} : {w[31:16], 16'h0};
    endfunction

    // Apply one wide cycle and check it against the bench model
    task automatic do_cycle(input bit rd, input bit sz, input logic [3:0] bs, input bit burst,
                            input logic [27:0] a, input logic [31:0] wd, input string tag);
        bit hit = (a[27:6] == BASE) && !burst;
        int idx = int'(a[5:2]);
        int lat = -1;
        logic [31:0] oe_exp, rd_exp, dword, oe_s, bo_s;
        logic [3:0] m;
        oe_s = '0; bo_s = '0;
        oe_exp = rd ? expand(exp_lanes(sz, bs)) : 32'h0;
        rd_exp = exp_read(model[idx], sz, a[1]);
        dword  = rd ? $urandom() : (sz ? wd : {wd[15:0], a[15:1], 1'b0});
        @(negedge clk);
        rnw = rd; wide_n = 1'b0; mux = 1'b1; bus_i = hdr_word(sz, bs, burst, a);
        @(negedge clk);
        mux = 1'b0;
        for (int k = 0; k < 2*ACK_DLY + 4; k++) begin
            @(negedge clk);
            if (k == 0) bus_i = dword;
            if (!hit) chk(ack_n && bus_oe == 0, {tag, " ignored cycle silent"}, {bus_oe[30:0], ack_n}, 32'h1);
            if (!ack_n && lat < 0) begin
                lat = k; oe_s = bus_oe; bo_s = bus_o;
            end
            if (lat >= 0) break;
        end
        if (hit) begin
            chk(lat == ACK_DLY, "R5 ack latency", lat, ACK_DLY);
            if (rd) begin
                chk(oe_s == oe_exp, {tag, " read lanes"}, oe_s, oe_exp);
                chk((bo_s & oe_s) == (rd_exp & oe_exp), {tag, " read data"}, bo_s & oe_s, rd_exp & oe_exp);
                if (!sz) chk(oe_s[15:0] == 16'h0, "R4 low lines undriven", oe_s, oe_s & 32'hFFFF0000);
            end else begin
                m = sz ? bs : (a[1] ? {2'b00, bs[3:2]} : {bs[3:2], 2'b00});
                for (int b = 0; b < 4; b++)
                    if (m[b]) model[idx][8*b +: 8] = sz ? wd[8*b +: 8] : wd[8*(b%2) +: 8];
            end
        end
        wide_n = 1'b1; mux = 1'b1;
        #1;
        chk(bus_oe == 0, "R6 lanes released", bus_oe, 32'h0);
        @(negedge clk);
        chk(ack_n == 1'b1, "R6 ack released", ack_n, 1);
        bus_i = $urandom();
    endtask

    function automatic logic [27:0] in_win(input int idx, input bit a1);
        return {BASE, 4'(idx), a1, 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset outputs
        chk(ack_n == 1'b1 && bus_oe == 0, "R1 reset state", {bus_oe[30:0], ack_n}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_n == 1'b1 && bus_oe == 0, "R1 after reset", {bus_oe[30:0], ack_n}, 32'h1);

        // R2/R3: full then partial 32-bit writes, reads with mixed selects
        do_cycle(0, 1, 4'hF, 0, in_win(3, 0), 32'hDEADBEEF, "R2");
        do_cycle(1, 1, 4'hF, 0, in_win(3, 0), 0, "R3 full");
        do_cycle(0, 1, 4'b0101, 0, in_win(3, 0), 32'h11223344, "R2");
        do_cycle(1, 1, 4'hF, 0, in_win(3, 0), 0, "R2 partial readback");
        chk(model[3] == 32'hDE22BE44, "R2 model mask", model[3], 32'hDE22BE44);
        do_cycle(1, 1, 4'b1001, 0, in_win(3, 0), 0, "R3 sparse");

        // R4: 16-bit halves
        do_cycle(0, 0, 4'b1100, 0, in_win(5, 0), 32'h0000CAFE, "R4");
        do_cycle(0, 0, 4'b1000, 0, in_win(5, 1), 32'h000012AB, "R4");
        do_cycle(1, 0, 4'b1100, 0, in_win(5, 0), 0, "R4 upper half");
        do_cycle(1, 0, 4'b1100, 0, in_win(5, 1), 0, "R4 lower half");
        do_cycle(1, 1, 4'hF, 0, in_win(5, 0), 0, "R4 word view");
        chk(model[5] == 32'hCAFE1200, "R4 model halves", model[5], 32'hCAFE1200);

        // R7: window miss leaves word untouched
        do_cycle(0, 1, 4'hF, 0, {BASE + 22'd1, 4'd7, 2'b00}, 32'hA5A5A5A5, "R7");
        do_cycle(1, 1, 4'hF, 0, {BASE ^ 22'h100, 4'd7, 2'b00}, 0, "R7");
        do_cycle(1, 1, 4'hF, 0, in_win(7, 0), 0, "R7 word unchanged");
        // R8: burst bit set is ignored
        do_cycle(0, 1, 4'hF, 1, in_win(7, 0), 32'h5A5A5A5A, "R8");
        do_cycle(1, 1, 4'hF, 0, in_win(7, 0), 0, "R8 word unchanged");

        // R10: phase toggles without strobe
        @(negedge clk);
        rnw = 1'b0; bus_i = hdr_word(1, 4'hF, 0, in_win(9, 0));
        for (int t = 0; t < 4; t++) begin
            @(negedge clk); mux = ~mux;
            chk(ack_n == 1'b1 && bus_oe == 0, "R10 no cycle without strobe", {bus_oe[30:0], ack_n}, 32'h1);
        end
        mux = 1'b1;
        do_cycle(1, 1, 4'hF, 0, in_win(9, 0), 0, "R10 word unchanged");

        // R9: random mix with junk on lines during data phases
        for (int n = 0; n < 80; n++) begin
            bit rd = $urandom_range(0, 1) == 1;
            bit sz = $urandom_range(0, 3) != 0;
            logic [3:0] bs = 4'($urandom());
            bit brst = $urandom_range(0, 9) == 0;
            logic [27:0] a = in_win($urandom_range(0, DEPTH - 1), $urandom_range(0, 1) == 1);
            if ($urandom_range(0, 6) == 0) a[27:6] = BASE ^ (22'h1 << $urandom_range(0, 21));
            if (sz) a[1] = 1'b0;
            do_cycle(rd, sz, bs, brst, a, $urandom(), "R9 random");
        end
        for (int i = 0; i < DEPTH; i++)
            do_cycle(1, 1, 4'hF, 0, in_win(i, 0), 0, "R9 final sweep");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule